// File: doc/BRIEF.md
# Eight-bit PWM timer/counter

An up/down timer with two compare channels that produce one waveform pin each. A 3-bit mode selects one of four behaviours:
- free counting to MAX;
- clear-on-compare counting, with TOP taken from channel A;
- single-slope (fast) PWM;
- dual-slope (phase-correct) PWM.

In the two PWM behaviours, TOP is either fixed at MAX or equal to channel A's compare value. MAX is all ones and BOTTOM is zero.

The counter advances only on cycles where an external prescaler raises `tick_i`. Software configures the block through a small register write port. The same port carries one-shot strobes that force a compare action on a pin. The overflow event and the two compare events come out as one-cycle flags, ready for an interrupt controller.

Compare values are double-buffered. Software writes a holding register, and the mode decides when the value becomes active: at once, at TOP or at BOTTOM.

Top module: `pwm_timer8`

## Requirements
- R1: After `rst_ni` is released, the following hold:
  - the counter is 0 and counts up;
  - the mode and both 2-bit output actions are 0;
  - both compare values are 0;
  - all pins and flags are low;
  - every register reads 0.
- R2: When `tick_i` is low, the counter holds its value, and no flag or compare-driven pin change occurs.
- R3: The mode is {ctlB bit 3, ctlA bits 1:0}:
  - 0 is free counting, with TOP at MAX;
  - 1 is dual-slope PWM, with TOP at MAX;
  - 2 is clear-on-compare, with TOP equal to compare A;
  - 3 is single-slope PWM, with TOP at MAX;
  - 5 is dual-slope PWM, with TOP equal to compare A;
  - 7 is single-slope PWM, with TOP equal to compare A;
  - 4 and 6 are reserved, and in them the counter holds and no events occur.
- R4: In modes 0, 2, 3 and 7, a tick at TOP or at MAX loads 0. Any other tick adds 1.
- R5: In modes 1 and 5, the counter counts up until a tick at or above TOP, which reverses it and moves it one step down. It then counts down to 0, where the next tick reverses it again and loads 1 (or 0 when TOP is 0).
- R6: The overflow flag pulses one cycle after a tick in these states:
  - in modes 0, 2 and 3, a tick at MAX;
  - in modes 1 and 5, a tick at 0 while counting down;
  - in mode 7, a tick at TOP.
- R7: A compare flag pulses one cycle after a tick on which the counter equals that channel's active compare value.
- R8: Writes to compare A (address 2) or compare B (address 3) go to a holding register, which reads back at once. The active copy updates at different points by mode:
  - in modes 0, 2, 4 and 6, it updates in the same cycle as the write;
  - in single-slope modes, it updates on the tick that wraps the counter to 0;
  - in dual-slope modes, it updates on the tick that reverses the counter at TOP.
- R9: The 2-bit output actions sit in ctlA: bits 7:6 for A and bits 5:4 for B. In modes 0 and 2, a match does the following to the pin: 01 toggles it, 10 clears it and 11 sets it.
- R10: In single-slope modes, action 10 clears the pin on a match and sets it on the wrap tick. Action 11 does the reverse. When a match and a wrap coincide, the wrap wins. Action 01 changes nothing.
- R11: In dual-slope modes, action 10 clears the pin on a match while counting up and sets it on a match while counting down. Action 11 does the reverse. Action 01 changes nothing.
- R12: Writing ctlB (address 1) with bit 7 set forces a compare action on pin A, using the mode in effect before the write; bit 6 does the same for pin B. This applies only in modes 0 and 2, and even there it raises no flag and leaves the counter untouched. In PWM modes the strobe has no effect.
- R13: Reading ctlB returns bits 7:6 as 0 and bit 3 as the mode MSB. ctlA (address 0) reads as {act A, act B, 00, mode[1:0]}, and addresses 2 and 3 return the holding registers.
- R14: While a channel's action is 00, its waveform output is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 ctlA, 1 ctlB, 2 compare A, 3 compare B |
| wr_data_i | input | W | Write data; control fields in bits 7:0 |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | W | Combinational read data |
| wave_a_o | output | 1 | Waveform pin A |
| wave_b_o | output | 1 | Waveform pin B |
| ovf_o | output | 1 | Overflow event pulse |
| cmp_a_o | output | 1 | Channel A compare pulse |
| cmp_b_o | output | 1 | Channel B compare pulse |

## Verification
The bench builds the block with W = 8. At that width a full free-running period is only 256 ticks, so a random run of a few hundred ticks per segment crosses MAX, the wrap to BOTTOM and both turning points of the dual-slope count many times. Mode, actions and compare values change at random while the count is in flight. This reaches the buffered-update corner, where a write lands just before the load point. Compare values of 0 and of TOP, force strobes in every mode and the reserved codes are driven directly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] M_NORM  = 3'd0;
  localparam logic [2:0] M_PCF   = 3'd1;
  localparam logic [2:0] M_CTC   = 3'd2;
  localparam logic [2:0] M_FASTF = 3'd3;
  localparam logic [2:0] M_PCO   = 3'd5;
  localparam logic [2:0] M_FASTO = 3'd7;

  localparam logic [1:0] ACT_OFF = 2'd0;
  localparam logic [1:0] ACT_TGL = 2'd1;
  localparam logic [1:0] ACT_CLR = 2'd2;
  localparam logic [1:0] ACT_SET = 2'd3;

  localparam logic [1:0] A_CTLA = 2'd0;
  localparam logic [1:0] A_CTLB = 2'd1;
  localparam logic [1:0] A_CMPA = 2'd2;
  localparam logic [1:0] A_CMPB = 2'd3;

  function automatic logic is_pc(input logic [2:0] m);
    return (m == M_PCF) || (m == M_PCO);
  endfunction

  function automatic logic is_fast(input logic [2:0] m);
    return (m == M_FASTF) || (m == M_FASTO);
  endfunction

  function automatic logic is_rsv(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd6);
  endfunction

  function automatic logic is_imm(input logic [2:0] m);
    return !is_pc(m) && !is_fast(m);
  endfunction

  function automatic logic top_from_cmp(input logic [2:0] m);
    return (m == M_CTC) || (m == M_PCO) || (m == M_FASTO);
  endfunction
endpackage

// File: rtl/tmr_count.sv
module tmr_count import tmr_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         up_o,
  output logic         run_o,
  output logic         wrap_o,
  output logic         turn_top_o,
  output logic         ovf_ev_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic         run, pc, turn_bot;

  assign pc         = is_pc(mode_i);
  assign run        = tick_i && !is_rsv(mode_i);
  assign wrap_o     = run && !pc && ((cnt_q == top_i) || (cnt_q == MAX));
  assign turn_top_o = run && pc && up_q && (cnt_q >= top_i);
  assign turn_bot   = run && pc && !up_q && (cnt_q == '0);

  always_comb begin
    unique case (mode_i)
      M_NORM, M_CTC, M_FASTF: ovf_ev_o = run && (cnt_q == MAX);
      M_PCF, M_PCO:           ovf_ev_o = turn_bot;
      M_FASTO:                ovf_ev_o = run && (cnt_q == top_i);
      default:                ovf_ev_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (run) begin
      if (!pc) begin
        cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (cnt_q >= top_i) begin
          up_q  <= 1'b0;
          cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= (top_i == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
  assign run_o = run;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R3
  rsv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rsv(mode_i) |=> $stable(cnt_q));
  // R4
  single_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pc && !is_rsv(mode_i) && cnt_q == MAX) |=> (cnt_q == '0));
  // R5
  pc_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pc && !up_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tmr_cmp_buf.sv
module tmr_cmp_buf import tmr_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   mode_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] hold_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i) hold_q <= wdata_i;
      if (is_imm(mode_i))  act_q <= wr_i ? wdata_i : hold_q;
      else if (load_i)     act_q <= hold_q;
    end
  end

  assign hold_o = hold_q;
  assign act_o  = act_q;

  // R8
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_imm(mode_i) && !load_i) |=> $stable(act_q));
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave import tmr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic [1:0] act_i,
  input  logic       match_i,
  input  logic       force_i,
  input  logic       up_i,
  input  logic       wrap_i,
  output logic       wave_o
);
  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (is_imm(mode_i)) begin
      if (match_i || force_i) begin
        unique case (act_i)
          ACT_TGL: pin_d = !pin_q;
          ACT_CLR: pin_d = 1'b0;
          ACT_SET: pin_d = 1'b1;
          default: pin_d = pin_q;
        endcase
      end
    end else if (is_fast(mode_i)) begin
      if (act_i == ACT_CLR) begin
        if (wrap_i)       pin_d = 1'b1;
        else if (match_i) pin_d = 1'b0;
      end else if (act_i == ACT_SET) begin
        if (wrap_i)       pin_d = 1'b0;
        else if (match_i) pin_d = 1'b1;
      end
    end else if (match_i) begin
      if (act_i == ACT_CLR)      pin_d = !up_i;
      else if (act_i == ACT_SET) pin_d = up_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign wave_o = (act_i == ACT_OFF) ? 1'b0 : pin_q;

  // R10
  fast_bottom_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_fast(mode_i) && act_i == ACT_CLR && wrap_i) |=> pin_q);
  // R12
  force_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_imm(mode_i) && act_i == ACT_TGL && force_i) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8 import tmr_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         wave_a_o,
  output logic         wave_b_o,
  output logic         ovf_o,
  output logic         cmp_a_o,
  output logic         cmp_b_o
);
  localparam int NCH = 2;
  localparam logic [W-1:0] MAX = '1;

  logic [2:0]              mode_q;
  logic [NCH-1:0][1:0]     act_q;
  logic [NCH-1:0][W-1:0]   hold_w, cmp_w;
  logic [NCH-1:0]          match_w, force_w, wave_w, flag_q;
  logic [W-1:0]            cnt_w, top_w;
  logic                    up_w, run_w, wrap_w, turn_w, ovf_ev_w, ovf_q;
  logic                    wr_ctla, wr_ctlb;

  assign wr_ctla = wr_en_i && (wr_addr_i == A_CTLA);
  assign wr_ctlb = wr_en_i && (wr_addr_i == A_CTLB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_ctla) begin
        act_q[0]    <= wr_data_i[7:6];
        act_q[1]    <= wr_data_i[5:4];
        mode_q[1:0] <= wr_data_i[1:0];
      end
      if (wr_ctlb) mode_q[2] <= wr_data_i[3];
    end
  end

  assign top_w = top_from_cmp(mode_q) ? cmp_w[0] : MAX;

  tmr_count #(.W(W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode_q),
    .top_i      (top_w),
    .cnt_o      (cnt_w),
    .up_o       (up_w),
    .run_o      (run_w),
    .wrap_o     (wrap_w),
    .turn_top_o (turn_w),
    .ovf_ev_o   (ovf_ev_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // force bit 7 drives channel A, bit 6 channel B
    assign force_w[ch] = wr_ctlb && wr_data_i[7-ch] && (mode_q == M_NORM || mode_q == M_CTC);
    assign match_w[ch] = run_w && (cnt_w == cmp_w[ch]);

    tmr_cmp_buf #(.W(W)) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode_q),
      .wr_i    (wr_en_i && (wr_addr_i == A_CMPA + 2'(ch))),
      .wdata_i (wr_data_i),
      .load_i  (is_fast(mode_q) ? wrap_w : turn_w),
      .hold_o  (hold_w[ch]),
      .act_o   (cmp_w[ch])
    );

    tmr_wave u_wave (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode_q),
      .act_i   (act_q[ch]),
      .match_i (match_w[ch]),
      .force_i (force_w[ch]),
      .up_i    (up_w),
      .wrap_i  (wrap_w),
      .wave_o  (wave_w[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      ovf_q  <= ovf_ev_w;
      flag_q <= match_w;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTLA:  rd_data_o[7:0] = {act_q[0], act_q[1], 2'b00, mode_q[1:0]};
      A_CTLB:  rd_data_o[7:0] = {4'b0000, mode_q[2], 3'b000};
      A_CMPA:  rd_data_o = hold_w[0];
      default: rd_data_o = hold_w[1];
    endcase
  end

  assign wave_a_o = wave_w[0];
  assign wave_b_o = wave_w[1];
  assign ovf_o    = ovf_q;
  assign cmp_a_o  = flag_q[0];
  assign cmp_b_o  = flag_q[1];

  // R6
  ovf_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (mode_q == M_NORM || mode_q == M_CTC || mode_q == M_FASTF) && cnt_w == MAX)
    |=> ovf_o);
  // R7
  cmp_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_a_o || cmp_b_o) |-> $past(tick_i));
  // R12
  force_pwm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctlb && !tick_i && !is_imm(mode_q)) |=> ($stable(wave_a_o) && $stable(wave_b_o)));
endmodule

// File: tb/pwm_timer8_tb_top.sv
module pwm_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic       wave_a_o, wave_b_o, ovf_o, cmp_a_o, cmp_b_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = !clk;

  pwm_timer8 #(.W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
    .ovf_o(ovf_o), .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o)
  );

  // reference state
  logic [7:0] m_cnt, m_hold[2], m_act[2];
  logic       m_up, m_pin[2], e_ovf, e_cmp[2];
  logic [2:0] m_mode;
  logic [1:0] m_com[2];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string wtag(input int c);
    if (m_com[c] == 2'd0)             return "R14";
    if (m_mode == 1 || m_mode == 5)   return "R11";
    if (m_mode == 3 || m_mode == 7)   return "R10";
    return "R9";
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_up = 1; m_mode = 0; e_ovf = 0;
    for (int c = 0; c < 2; c++) begin
      m_hold[c] = 0; m_act[c] = 0; m_pin[c] = 0; m_com[c] = 0; e_cmp[c] = 0;
    end
  endtask

  task automatic model(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    logic rsv, pc, fast, imm, run, wrap, ttop, tbot, ld;
    logic [7:0] top;
    logic mt[2], frc[2];
    rsv  = (m_mode == 4) || (m_mode == 6);
    pc   = (m_mode == 1) || (m_mode == 5);
    fast = (m_mode == 3) || (m_mode == 7);
    imm  = !pc && !fast;
    run  = t && !rsv;
    top  = (m_mode == 2 || m_mode == 5 || m_mode == 7) ? m_act[0] : 8'hFF;
    for (int c = 0; c < 2; c++) begin
      mt[c]  = run && (m_cnt == m_act[c]);
      frc[c] = w && (a == 2'd1) && d[7-c] && (m_mode == 0 || m_mode == 2);
    end
    wrap = run && !pc && (m_cnt == top || m_cnt == 8'hFF);
    ttop = run && pc && m_up && (m_cnt >= top);
    tbot = run && pc && !m_up && (m_cnt == 0);
    case (m_mode)
      0, 2, 3: e_ovf = run && (m_cnt == 8'hFF);
      1, 5:    e_ovf = tbot;
      7:       e_ovf = run && (m_cnt == top);
      default: e_ovf = 0;
    endcase
    for (int c = 0; c < 2; c++) begin
      e_cmp[c] = mt[c];
      if (imm) begin
        if (mt[c] || frc[c])
          case (m_com[c])
            1: m_pin[c] = !m_pin[c];
            2: m_pin[c] = 0;
            3: m_pin[c] = 1;
            default: ;
          endcase
      end else if (fast) begin
        if (m_com[c] == 2) begin
          if (wrap) m_pin[c] = 1; else if (mt[c]) m_pin[c] = 0;
        end else if (m_com[c] == 3) begin
          if (wrap) m_pin[c] = 0; else if (mt[c]) m_pin[c] = 1;
        end
      end else if (mt[c]) begin
        if (m_com[c] == 2) m_pin[c] = !m_up;
        else if (m_com[c] == 3) m_pin[c] = m_up;
      end
    end
    ld = fast ? wrap : ttop;
    for (int c = 0; c < 2; c++) begin
      if (imm) m_act[c] = (w && a == 2'(2 + c)) ? d : m_hold[c];
      else if (ld) m_act[c] = m_hold[c];
      if (w && a == 2'(2 + c)) m_hold[c] = d;
    end
    if (run) begin
      if (!pc) begin
        m_cnt = wrap ? 8'd0 : m_cnt + 8'd1; m_up = 1;
      end else if (m_up) begin
        if (m_cnt >= top) begin m_up = 0; m_cnt = (m_cnt == 0) ? 8'd0 : m_cnt - 8'd1; end
        else m_cnt = m_cnt + 8'd1;
      end else if (m_cnt == 0) begin
        m_up = 1; m_cnt = (top == 0) ? 8'd0 : 8'd1;
      end else m_cnt = m_cnt - 8'd1;
    end
    if (w && a == 0) begin
      m_com[0] = d[7:6]; m_com[1] = d[5:4]; m_mode[1:0] = d[1:0];
    end
    if (w && a == 1) m_mode[2] = d[3];
  endtask

  task automatic compare();
    chk(wtag(0), "wave_a", wave_a_o, (m_com[0] == 0) ? 0 : m_pin[0]);
    chk(wtag(1), "wave_b", wave_b_o, (m_com[1] == 0) ? 0 : m_pin[1]);
    chk("R6", "ovf", ovf_o, e_ovf);
    chk("R7", "cmp_a", cmp_a_o, e_cmp[0]);
    chk("R7", "cmp_b", cmp_b_o, e_cmp[1]);
  endtask

  task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_i = t; wr_en_i = w; wr_addr_i = a; wr_data_i = d;
    model(t, w, a, d);
    @(posedge clk); #1;
    tick_i = 0; wr_en_i = 0;
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr_i = a; #1;
    chk(req, "rd_data", rd_data_o, exp);
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [1:0] ca, input logic [1:0] cb);
    wr(2'd0, {ca, cb, 2'b00, m[1:0]});
    wr(2'd1, {4'b0, m[2], 3'b0});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes[6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7};
    logic       prev;
    void'($urandom(32'h5A17));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    #1;
    // R1 reset state
    compare();
    for (int a = 0; a < 4; a++) rd_chk("R1", 2'(a), 8'h00);

    // R4 R6 R9: free count with toggle on A, set on B
    set_mode(3'd0, 2'd1, 2'd3);
    wr(2'd2, 8'h10); wr(2'd3, 8'hF0);
    rd_chk("R8", 2'd2, 8'h10);
    tk(600);
    // R2: sparse ticks
    for (int i = 0; i < 200; i++) step(($urandom % 4) == 0, 1'b0, 2'd0, 8'd0);

    // R3 R4 R7: clear-on-compare with TOP = 9
    set_mode(3'd2, 2'd1, 2'd2);
    wr(2'd2, 8'd9); wr(2'd3, 8'd4);
    tk(60);
    // R12: force toggles A, no flag, counter unaffected
    prev = wave_a_o;
    wr(2'd1, 8'h80);
    chk("R12", "forced wave_a", wave_a_o, !prev);
    chk("R12", "forced cmp_a", cmp_a_o, 0);
    tk(30);

    // R11 R5 R13: dual-slope TOP from A, force ignored
    set_mode(3'd5, 2'd2, 2'd3);
    wr(2'd2, 8'd20); wr(2'd3, 8'd7);
    prev = wave_a_o;
    wr(2'd1, 8'hC8);
    chk("R12", "pwm force ignored", wave_a_o, prev);
    rd_chk("R13", 2'd1, 8'h08);
    rd_chk("R13", 2'd0, 8'hB1);
    tk(100);
    // R8: update at TOP
    wr(2'd3, 8'd15);
    tk(120);

    // R10: single-slope, compare equal TOP and compare zero
    set_mode(3'd7, 2'd2, 2'd2);
    wr(2'd2, 8'd30); wr(2'd3, 8'd30);
    tk(80);
    wr(2'd3, 8'd0);
    tk(80);
    set_mode(3'd3, 2'd3, 2'd1);
    wr(2'd2, 8'd100);
    tk(600);

    // R3: reserved mode holds
    set_mode(3'd4, 2'd1, 2'd1);
    tk(50);
    set_mode(3'd6, 2'd2, 2'd2);
    tk(20);
    // R14: action 00 drives low
    set_mode(3'd0, 2'd0, 2'd0);
    tk(300);

    // constrained random
    for (int seg = 0; seg < 120; seg++) begin
      logic [2:0] m;
      m = modes[$urandom % 6];
      if (($urandom % 20) == 0) m = 3'd4;
      set_mode(m, 2'($urandom), 2'($urandom));
      wr(2'd2, (m == 2 || m == 5 || m == 7) ? 8'($urandom % 64) : 8'($urandom));
      wr(2'd3, 8'($urandom));
      for (int i = 0; i < 300; i++) begin
        int r;
        r = $urandom % 100;
        if (r < 2)      step(($urandom % 2) == 1, 1'b1, 2'(2 + ($urandom % 2)), 8'($urandom % 64));
        else if (r < 3) step(($urandom % 2) == 1, 1'b1, 2'd1, {2'($urandom), 3'b0, m[2], 3'b0});
        else            step(($urandom % 4) != 0, 1'b0, 2'd0, 8'd0);
      end
      rd_chk("R13", 2'd1, {4'b0, m_mode[2], 3'b0});
      rd_chk("R8", 2'd3, m_hold[1]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule